// File: doc/BRIEF.md
# Two-Wire Dual DAC Command Slave

This block is the command front end of a dual 10-bit DAC channel pair. It watches a two-wire serial bus (clock line and open-drain data line) with a fast system clock, finds start and stop conditions, and accepts write transfers addressed to it. The first byte after a start carries a seven-bit address: a four-bit device type fixed by a parameter, then the three address pins. The block pulls the data line low to acknowledge.

The byte after the address is a command. It either starts a three-byte data write to DAC1, DAC2 or both, or it is a two-byte preset that zeroes, fills with ones, recalls the stored value, or powers down one or both channels. Each decoded action leaves the block as a one-cycle strobe, together with a channel mask (bit 0 for DAC1, bit 1 for DAC2) and a 10-bit value. A data write that is followed directly by a stop condition also asks for a nonvolatile store. The register file, the analog path, the nonvolatile array and bus reads are outside this block.

Top module: `dual_dac_cmd_slave`

## Requirements
- R1: The first byte after a start is {device type (default 4'b0101), address pins A2..A0, read/write flag} from bit 7 down to bit 0. The block acknowledges it (drives `sda_oe_o` high through the ninth clock) only when bits 7:1 match. On a mismatch it gives no acknowledge and ignores the rest of the transfer.
- R2: After a matching address with the flag at 0, every further byte is acknowledged. Command bytes not covered by R3, R5, R6 and R7 cause no strobe and no change on `chan_mask_o` or `data_o`.
- R3: Command upper nibble 4'b1001, 4'b1010 or 4'b1011 selects mask 2'b01, 2'b10 or 2'b11. The command's bits 1:0 are data bits 9:8 and the third byte gives bits 7:0. `wr_stb_o` pulses once, with that mask and value, right after the third byte's acknowledge clock ends.
- R4: When a stop follows a complete R3 write with no SCL falling edge and no start in between, `nv_stb_o` pulses one cycle after the stop, keeping the write's mask and data. Otherwise no store is requested.
- R5: Command bytes 8'hDE, 8'hDD and 8'hDF pulse `zero_stb_o` with mask 01, 10 and 11 and data 10'h000.
- R6: Command bytes 8'hEE, 8'hED and 8'hEF pulse `full_stb_o` with mask 01, 10 and 11 and data 10'h3FF.
- R7: Upper nibble 4'b1111 pulses `recall_stb_o` and upper nibble 4'b1000 pulses `pd_stb_o`. Bits 1:0 map 2'b10 to mask 01, 2'b01 to mask 10 and 2'b11 to mask 11. Bits 1:0 = 00 does nothing. `data_o` keeps its previous value.
- R8: The preset commands of R5 to R7 take effect when the command byte is acknowledged, whether or not a stop follows. A stop after them never requests a store.
- R9: A start at any point aborts the transfer in progress, and the next byte is treated as an address.
- R10: A matching address with the flag at 1 is acknowledged. Until the next start, no further byte is acknowledged and no strobe fires.
- R11: After reset every strobe, `chan_mask_o`, `data_o` and `sda_oe_o` are 0.
- R12: Every strobe is exactly one cycle wide, and at most one strobe is high in any cycle.
- R13: `sda_oe_o` changes only while SCL is low, except when a start or stop releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the bus, asynchronous |
| addr_pins_i | input | 3 | Address pins A2..A0 |
| sda_oe_o | output | 1 | High pulls the data line low |
| wr_stb_o | output | 1 | Volatile write strobe |
| nv_stb_o | output | 1 | Nonvolatile store strobe |
| zero_stb_o | output | 1 | Zero-scale preset strobe |
| full_stb_o | output | 1 | Full-scale preset strobe |
| recall_stb_o | output | 1 | Recall-stored-value strobe |
| pd_stb_o | output | 1 | Power-down strobe |
| chan_mask_o | output | 2 | Channel mask, bit 0 DAC1, bit 1 DAC2 |
| data_o | output | 10 | Value belonging to the latest strobe |

## Verification
The bench sends all 128 address bytes and all 256 command bytes, each as a two-byte transfer, and works out the expected acknowledge, strobe kind, mask and data arithmetically. A wrong address compare would acknowledge a foreign device. A sloppy decode would fire presets for don't-care patterns or for a zero selector. A wrong `data_o` update would show up when recall or power-down runs after a preset.

Data writes are sent with the boundary values 000 and 3FF, with alternating patterns, and to every channel selection. Each write is closed either by a stop directly or by an extra byte first, so a store that ignores intervening clocks would be requested wrongly. A start in the middle of a byte, and a read-flagged address followed by clocked bits, check that a design which kept its byte counter would not take the next byte as a command.

// File: rtl/dac_cmd_pkg.sv
// Shared types and helpers for the two-wire dual DAC command slave.
package dac_cmd_pkg;

    // Byte engine states: not addressed, shifting bits, acknowledging, skipping
    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_BITS = 2'd1,
        BUS_ACK  = 2'd2,
        BUS_SKIP = 2'd3
    } bus_state_e;

    localparam int          BYTE_W       = 8;
    localparam int          CHAN_N       = 2;
    localparam logic [3:0]  NIB_WR_CH1   = 4'b1001;
    localparam logic [3:0]  NIB_WR_CH2   = 4'b1010;
    localparam logic [3:0]  NIB_WR_BOTH  = 4'b1011;
    localparam logic [3:0]  NIB_ZERO     = 4'b1101;
    localparam logic [3:0]  NIB_FULL     = 4'b1110;
    localparam logic [3:0]  NIB_RECALL   = 4'b1111;
    localparam logic [3:0]  NIB_PDOWN    = 4'b1000;

    // Channel selector (10 = DAC1, 01 = DAC2, 11 = both) to mask (bit0 = DAC1)
    function automatic logic [CHAN_N-1:0] sel_to_mask(input logic [1:0] sel);
        return {sel[0], sel[1]};
    endfunction

endpackage

// File: rtl/tw_line_sync.sv
// Two-wire line synchronizer and event detector.
// Does: brings SCL and SDA into the clk domain through SYNC_STAGES flops and
//       flags SCL edges plus start/stop conditions as one-cycle pulses.
// Assumes: clk runs several times faster than SCL; idle bus level is high.
module tw_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl_o,
    output logic sda_lvl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
    logic                   scl_q, sda_q;

    // Synchronizer chains plus one history stage, reset to the idle-high bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[LAST];
            sda_q    <= sda_pipe[LAST];
        end
    end

    // Edge and condition decode on the synchronized levels
    always_comb begin
        scl_lvl_o  = scl_pipe[LAST];
        sda_lvl_o  = sda_pipe[LAST];
        scl_rise_o = scl_pipe[LAST] & ~scl_q;
        scl_fall_o = ~scl_pipe[LAST] & scl_q;
        start_o    = scl_pipe[LAST] & scl_q & sda_q & ~sda_pipe[LAST];
        stop_o     = scl_pipe[LAST] & scl_q & ~sda_q & sda_pipe[LAST];
    end

endmodule

// File: rtl/tw_byte_engine.sv
// Two-wire byte engine.
// Does: shifts in bits on SCL rising edges, checks the address byte, drives
//       the acknowledge during the ninth clock and hands each acknowledged
//       byte to the decoder together with its position in the transfer.
// Assumes: event pulses come from tw_line_sync; byte position saturates at 3.
module tw_byte_engine
    import dac_cmd_pkg::*;
#(
    parameter logic [3:0] DEV_TYPE = 4'b0101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        addr_pins_i,
    input  logic              scl_lvl_i,
    input  logic              sda_lvl_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    output logic              sda_oe_o,
    output logic              byte_stb_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic [1:0]        byte_idx_o
);
    localparam logic [3:0] BIT_LAST = 4'(BYTE_W);
    localparam logic [1:0] IDX_MAX  = 2'd3;

    bus_state_e        state;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [1:0]        idx;
    logic              rd_req;
    logic              addr_hit;

    // Address compare on the collected first byte
    always_comb addr_hit = (shreg[BYTE_W-1:1] == {DEV_TYPE, addr_pins_i});

    // Bit collection, acknowledge drive and byte hand-off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= BUS_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            idx        <= '0;
            rd_req     <= 1'b0;
            sda_oe_o   <= 1'b0;
            byte_stb_o <= 1'b0;
            byte_o     <= '0;
            byte_idx_o <= '0;
        end else begin
            byte_stb_o <= 1'b0;
            if (start_i) begin
                state    <= BUS_BITS;
                bit_cnt  <= '0;
                idx      <= '0;
                rd_req   <= 1'b0;
                sda_oe_o <= 1'b0;
            end else if (stop_i) begin
                state    <= BUS_IDLE;
                sda_oe_o <= 1'b0;
            end else begin
                case (state)
                    BUS_BITS: begin
                        if (scl_rise_i && bit_cnt < BIT_LAST) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_lvl_i};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall_i && bit_cnt == BIT_LAST) begin
                            if (idx != 2'd0) begin
                                state    <= BUS_ACK;
                                sda_oe_o <= 1'b1;
                            end else if (addr_hit) begin
                                state    <= BUS_ACK;
                                sda_oe_o <= 1'b1;
                                rd_req   <= shreg[0];
                            end else begin
                                state <= BUS_SKIP;
                            end
                        end
                    end
                    BUS_ACK: begin
                        if (scl_fall_i) begin
                            sda_oe_o   <= 1'b0;
                            bit_cnt    <= '0;
                            byte_stb_o <= 1'b1;
                            byte_o     <= shreg;
                            byte_idx_o <= idx;
                            idx        <= (idx == IDX_MAX) ? IDX_MAX : idx + 2'd1;
                            state      <= rd_req ? BUS_SKIP : BUS_BITS;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R13
    sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe_o) && !$past(start_i) && !$past(stop_i)) |-> !scl_lvl_i);

    // R1
    ack_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> $past(scl_fall_i));

    // R9
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!sda_oe_o && !byte_stb_o));

endmodule

// File: rtl/dac_cmd_decoder.sv
// Command decoder for the dual DAC slave.
// Does: turns acknowledged bytes into one-cycle action strobes with a channel
//       mask and value, and arms a nonvolatile store after a complete write.
// Assumes: byte position 1 is the command, 2 the low data byte; DATA_W > 8.
module dac_cmd_decoder
    import dac_cmd_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_stb_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [1:0]        byte_idx_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    output logic              wr_stb_o,
    output logic              nv_stb_o,
    output logic              zero_stb_o,
    output logic              full_stb_o,
    output logic              recall_stb_o,
    output logic              pd_stb_o,
    output logic [CHAN_N-1:0] chan_mask_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int HI_W = DATA_W - BYTE_W;

    logic [3:0]        nib;
    logic [1:0]        sel;
    logic [CHAN_N-1:0] sel_mask;
    logic              is_write, is_zero, is_full, is_recall, is_pd;
    logic              wr_pend, nv_armed;
    logic [HI_W-1:0]   hi_bits;
    logic [CHAN_N-1:0] pend_mask;

    // Command byte classification
    always_comb begin
        nib       = byte_i[7:4];
        sel       = byte_i[1:0];
        sel_mask  = sel_to_mask(sel);
        is_write  = (nib == NIB_WR_CH1) || (nib == NIB_WR_CH2) || (nib == NIB_WR_BOTH);
        is_zero   = (nib == NIB_ZERO) && (byte_i[3:2] == 2'b11) && (sel != 2'b00);
        is_full   = (nib == NIB_FULL) && (byte_i[3:2] == 2'b11) && (sel != 2'b00);
        is_recall = (nib == NIB_RECALL) && (sel != 2'b00);
        is_pd     = (nib == NIB_PDOWN) && (sel != 2'b00);
    end

    // Strobe generation, pending-write tracking and store arming
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb_o     <= 1'b0;
            nv_stb_o     <= 1'b0;
            zero_stb_o   <= 1'b0;
            full_stb_o   <= 1'b0;
            recall_stb_o <= 1'b0;
            pd_stb_o     <= 1'b0;
            chan_mask_o  <= '0;
            data_o       <= '0;
            wr_pend      <= 1'b0;
            nv_armed     <= 1'b0;
            hi_bits      <= '0;
            pend_mask    <= '0;
        end else begin
            wr_stb_o     <= 1'b0;
            nv_stb_o     <= 1'b0;
            zero_stb_o   <= 1'b0;
            full_stb_o   <= 1'b0;
            recall_stb_o <= 1'b0;
            pd_stb_o     <= 1'b0;
            if (start_i) begin
                wr_pend  <= 1'b0;
                nv_armed <= 1'b0;
            end else begin
                if (scl_fall_i) nv_armed <= 1'b0;
                if (stop_i) begin
                    nv_stb_o <= nv_armed;
                    nv_armed <= 1'b0;
                    wr_pend  <= 1'b0;
                end
                if (byte_stb_i) begin
                    case (byte_idx_i)
                        2'd1: begin
                            wr_pend   <= is_write;
                            hi_bits   <= byte_i[HI_W-1:0];
                            pend_mask <= nib[1:0];
                            if (is_zero) begin
                                zero_stb_o  <= 1'b1;
                                chan_mask_o <= sel_mask;
                                data_o      <= '0;
                            end
                            if (is_full) begin
                                full_stb_o  <= 1'b1;
                                chan_mask_o <= sel_mask;
                                data_o      <= '1;
                            end
                            if (is_recall) begin
                                recall_stb_o <= 1'b1;
                                chan_mask_o  <= sel_mask;
                            end
                            if (is_pd) begin
                                pd_stb_o    <= 1'b1;
                                chan_mask_o <= sel_mask;
                            end
                        end
                        2'd2: begin
                            if (wr_pend) begin
                                wr_stb_o    <= 1'b1;
                                chan_mask_o <= pend_mask;
                                data_o      <= {hi_bits, byte_i};
                                nv_armed    <= 1'b1;
                            end
                            wr_pend <= 1'b0;
                        end
                        default: wr_pend <= 1'b0;
                    endcase
                end
            end
        end
    end

    // R12
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_stb_o, nv_stb_o, zero_stb_o, full_stb_o, recall_stb_o, pd_stb_o}));

    // R4
    nv_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nv_stb_o |-> $past(stop_i));

    // R3
    wr_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> ($past(byte_stb_i) && $past(byte_idx_i) == 2'd2));

    // R8
    preset_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_stb_o || full_stb_o || recall_stb_o || pd_stb_o) |=> !nv_stb_o);

endmodule

// File: rtl/dual_dac_cmd_slave.sv
// Two-wire dual DAC command slave, top level.
// Does: joins the line synchronizer, byte engine and command decoder.
// Assumes: sda_i is the resolved bus level including this block's own pull-down.
module dual_dac_cmd_slave
    import dac_cmd_pkg::*;
#(
    parameter logic [3:0] DEV_TYPE    = 4'b0101,
    parameter int         SYNC_STAGES = 2,
    parameter int         DATA_W      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        addr_pins_i,
    output logic              sda_oe_o,
    output logic              wr_stb_o,
    output logic              nv_stb_o,
    output logic              zero_stb_o,
    output logic              full_stb_o,
    output logic              recall_stb_o,
    output logic              pd_stb_o,
    output logic [CHAN_N-1:0] chan_mask_o,
    output logic [DATA_W-1:0] data_o
);
    logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic              byte_stb;
    logic [BYTE_W-1:0] byte_val;
    logic [1:0]        byte_idx;

    tw_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_lvl_o  (scl_lvl),
        .sda_lvl_o  (sda_lvl),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    tw_byte_engine #(.DEV_TYPE(DEV_TYPE)) u_bytes (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_pins_i (addr_pins_i),
        .scl_lvl_i   (scl_lvl),
        .sda_lvl_i   (sda_lvl),
        .scl_rise_i  (scl_rise),
        .scl_fall_i  (scl_fall),
        .start_i     (start_det),
        .stop_i      (stop_det),
        .sda_oe_o    (sda_oe_o),
        .byte_stb_o  (byte_stb),
        .byte_o      (byte_val),
        .byte_idx_o  (byte_idx)
    );

    dac_cmd_decoder #(.DATA_W(DATA_W)) u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_stb_i   (byte_stb),
        .byte_i       (byte_val),
        .byte_idx_i   (byte_idx),
        .scl_fall_i   (scl_fall),
        .start_i      (start_det),
        .stop_i       (stop_det),
        .wr_stb_o     (wr_stb_o),
        .nv_stb_o     (nv_stb_o),
        .zero_stb_o   (zero_stb_o),
        .full_stb_o   (full_stb_o),
        .recall_stb_o (recall_stb_o),
        .pd_stb_o     (pd_stb_o),
        .chan_mask_o  (chan_mask_o),
        .data_o       (data_o)
    );

endmodule

// File: tb/tb_dual_dac_cmd_slave.sv
// Bench: sweeps every address and command byte, then targeted write,
// abort and read cases; expected values computed from the requirements.
module tb_dual_dac_cmd_slave;
    localparam int Q = 5;
    localparam logic [3:0] TYPE = 4'b0101;
    localparam logic [5:0] K_WR = 6'b100000, K_NV = 6'b010000, K_ZERO = 6'b001000,
                           K_FULL = 6'b000100, K_RCL = 6'b000010, K_PD = 6'b000001,
                           K_NONE = 6'b000000;

    logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
    logic [2:0] pins = 3'b101;
    logic sda_oe, wr, nv, zr, fl, rc, pd;
    logic [1:0] mask;
    logic [9:0] data;
    wire  sda_line = sda_m & ~sda_oe;

    int n_chk = 0, n_bad = 0, ev_cnt = 0;
    logic [5:0] ev_kind = '0;
    logic [1:0] ev_mask = '0;
    logic [9:0] ev_data = '0;
    logic [9:0] cur_data = '0;
    bit   done = 0;

    always #2.5 clk = ~clk;

    dual_dac_cmd_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .addr_pins_i(pins),
        .sda_oe_o(sda_oe), .wr_stb_o(wr), .nv_stb_o(nv), .zero_stb_o(zr),
        .full_stb_o(fl), .recall_stb_o(rc), .pd_stb_o(pd),
        .chan_mask_o(mask), .data_o(data)
    );

    // Event monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && (wr | nv | zr | fl | rc | pd)) begin
            ev_cnt  = ev_cnt + 1;
            ev_kind = {wr, nv, zr, fl, rc, pd};
            ev_mask = mask;
            ev_data = data;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_q(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; wait_q(Q); scl_m = 1'b1; wait_q(Q); scl_m = 1'b0; wait_q(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        sda_m = 1'b1; wait_q(Q); scl_m = 1'b1; wait_q(2);
        acked = ~sda_line;
        wait_q(Q - 2); scl_m = 1'b0; wait_q(Q);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q(Q); scl_m = 1'b1; wait_q(Q);
        sda_m = 1'b0; wait_q(Q); scl_m = 1'b0; wait_q(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q(Q); scl_m = 1'b1; wait_q(Q); sda_m = 1'b1; wait_q(Q);
    endtask

    function automatic logic [1:0] map_sel(input logic [1:0] s);
        return {s[0], s[1]};
    endfunction

    // Expected reaction to a two-byte command, from R2, R5, R6, R7
    task automatic exp_cmd(input logic [7:0] c, output logic [5:0] k,
                           output logic [1:0] m, output logic [9:0] d);
        k = K_NONE; m = map_sel(c[1:0]); d = cur_data;
        if (c[1:0] != 2'b00) begin
            if (c[7:4] == 4'b1101 && c[3:2] == 2'b11) begin k = K_ZERO; d = 10'h000; end
            else if (c[7:4] == 4'b1110 && c[3:2] == 2'b11) begin k = K_FULL; d = 10'h3FF; end
            else if (c[7:4] == 4'b1111) k = K_RCL;
            else if (c[7:4] == 4'b1000) k = K_PD;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic ak;
        logic [5:0] k;
        logic [1:0] m;
        logic [9:0] d;
        int e0;
        logic [9:0] vals [4];
        vals[0] = 10'h000; vals[1] = 10'h3FF; vals[2] = 10'h155; vals[3] = 10'h2AA;

        wait_q(4); rst_n = 1'b1; wait_q(4);
        // R11 reset state
        chk("R11 strobes", {26'd0, wr, nv, zr, fl, rc, pd}, 32'd0);
        chk("R11 mask/data", {20'd0, mask, data}, 32'd0);
        chk("R11 sda_oe", {31'd0, sda_oe}, 32'd0);

        // R1 address sweep with fixed pins
        for (int a = 0; a < 128; a++) begin
            bus_start(); send_byte({a[6:0], 1'b0}, ak); bus_stop();
            chk("R1 addr ack", {31'd0, ak}, {31'd0, (a[6:0] == {TYPE, pins})});
        end
        // R1 pin sweep
        for (int p = 0; p < 8; p++) begin
            pins = p[2:0];
            bus_start(); send_byte({TYPE, p[2:0], 1'b0}, ak); bus_stop();
            chk("R1 pin ack", {31'd0, ak}, 32'd1);
        end
        pins = 3'b101;
        // R1 mismatched address: later command neither acked nor executed
        e0 = ev_cnt;
        bus_start(); send_byte({TYPE, 3'b100, 1'b0}, ak); send_byte(8'hDF, ak); bus_stop();
        chk("R1 foreign cmd ack", {31'd0, ak}, 32'd0);
        chk("R1 foreign no event", ev_cnt - e0, 32'd0);

        // R2 R5 R6 R7 R8 command sweep
        for (int c = 0; c < 256; c++) begin
            exp_cmd(c[7:0], k, m, d);
            e0 = ev_cnt;
            bus_start(); send_byte({TYPE, pins, 1'b0}, ak); send_byte(c[7:0], ak);
            chk("R2 cmd ack", {31'd0, ak}, 32'd1);
            wait_q(2);
            if (k == K_NONE) chk("R2 ignored cmd", ev_cnt - e0, 32'd0);
            else begin
                chk("R8 preset before stop", ev_cnt - e0, 32'd1);
                chk("R5/R6/R7 kind", {26'd0, ev_kind}, {26'd0, k});
                chk("R5/R6/R7 mask", {30'd0, ev_mask}, {30'd0, m});
                chk("R7 data", {22'd0, ev_data}, {22'd0, d});
                cur_data = d;
            end
            e0 = ev_cnt;
            bus_stop(); wait_q(3);
            chk("R8 no store after preset", ev_cnt - e0, 32'd0);
        end

        // R3 R4 data writes, all channels, boundary values, stop or extra byte
        for (int n = 0; n < 3; n++) begin
            for (int v = 0; v < 4; v++) begin
                for (int s = 0; s < 2; s++) begin
                    logic [3:0] nib;
                    nib = 4'b1001 + 4'(n);
                    e0 = ev_cnt;
                    bus_start(); send_byte({TYPE, pins, 1'b0}, ak);
                    send_byte({nib, 2'(v), vals[v][9:8]}, ak);
                    send_byte(vals[v][7:0], ak);
                    wait_q(2);
                    chk("R3 write event", ev_cnt - e0, 32'd1);
                    chk("R3 kind", {26'd0, ev_kind}, {26'd0, K_WR});
                    chk("R3 mask", {30'd0, ev_mask}, {30'd0, nib[1:0]});
                    chk("R3 data", {22'd0, ev_data}, {22'd0, vals[v]});
                    cur_data = vals[v];
                    if (s == 1) send_byte(8'h00, ak);
                    bus_stop(); wait_q(3);
                    if (s == 0) begin
                        chk("R4 store event", ev_cnt - e0, 32'd2);
                        chk("R4 store kind", {26'd0, ev_kind}, {26'd0, K_NV});
                        chk("R4 store mask/data", {20'd0, ev_mask, ev_data},
                            {20'd0, nib[1:0], vals[v]});
                    end else begin
                        chk("R4 no store after extra byte", ev_cnt - e0, 32'd1);
                    end
                end
            end
        end
        // R4 repeated start cancels the store
        e0 = ev_cnt;
        bus_start(); send_byte({TYPE, pins, 1'b0}, ak); send_byte(8'hB2, ak);
        send_byte(8'h34, ak); bus_start(); bus_stop(); wait_q(3);
        chk("R4 start cancels store", ev_cnt - e0, 32'd1);
        chk("R3 both-channel data", {22'd0, ev_data}, 32'h234);

        // R9 start mid-byte aborts, next byte is an address
        e0 = ev_cnt;
        bus_start(); send_byte({TYPE, pins, 1'b0}, ak);
        bit_out(1'b1); bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
        bus_start(); send_byte({TYPE, pins, 1'b0}, ak);
        chk("R9 address after abort acked", {31'd0, ak}, 32'd1);
        send_byte(8'hEE, ak); wait_q(2);
        chk("R9 one event", ev_cnt - e0, 32'd1);
        chk("R9 full DAC1", {24'd0, ev_kind, ev_mask}, {24'd0, K_FULL, 2'b01});
        bus_stop();

        // R10 read-flagged address: acked, then nothing
        e0 = ev_cnt;
        bus_start(); send_byte({TYPE, pins, 1'b1}, ak);
        chk("R10 read addr ack", {31'd0, ak}, 32'd1);
        send_byte(8'hDF, ak);
        chk("R10 no data ack", {31'd0, ak}, 32'd0);
        bus_stop(); wait_q(3);
        chk("R10 no event", ev_cnt - e0, 32'd0);

        finish_run();
    end
endmodule